// File: doc/BRIEF.md
# Watchdog Configuration Guard

This block holds the configuration of a watchdog timer: a control byte with run, interrupt, update-permission and low-power/debug run bits; a second control byte with window-check enable, prescaler enable and a clock-source selector; a 16-bit timeout and a 16-bit window value. All of it is written over a 16-bit bus word port with two byte strobes. The counter, refresh check and reset generation sit elsewhere and only read the decoded outputs.

After reset every configuration byte may be written freely. The first write to the primary control byte commits the configuration. From then on, writes are dropped unless software first opens a short update window. It does this by writing two fixed 16-bit keys to the key address in quick succession. The window opens only when the committed update-permission bit is set. It stays open for a fixed number of bus clocks and then shuts without further action.

Word addresses are 0 for the control word (low lane: primary control byte, high lane: secondary control byte), 1 for the key word, 2 for the timeout and 3 for the window value. In the timeout and window words the low lane is the low byte.

Top module: `wdcfg_guard`

## Requirements
- R1: On reset the outputs return to the defaults: run enable 1, every other primary control bit 0, clock select 2'b01, window-check and prescaler enables 0, timeout 16'h0400, window 16'h0000. Reset also restores free writing.
- R2: Before the configuration is committed, a write stores only the byte lanes whose strobe is set (strobe bit 0 is data[7:0], bit 1 is data[15:8]). The other lanes of that register keep their values.
- R3: A write with strobe bit 0 set to control word address 0 commits the configuration. Any later write to addresses 0, 2 or 3 outside an open update window leaves every output unchanged. A secondary-byte-only write does not commit.
- R4: A full-word (strobe 2'b11) write of 16'h20C5 to address 1, followed by 16'h28D9 to address 1 one to 16 clocks later, opens the update window.
- R5: A second key that arrives 17 or more clocks after the first does not open the window.
- R6: Any other full-word value written to address 1 between the two keys cancels the sequence, so the following second key opens nothing.
- R7: The window accepts writes in the 128 clocks after the clock of the second key, counting that clock as zero. A write 129 clocks after it is ignored.
- R8: When the configuration is committed and the committed update bit is 0, the key sequence has no effect and the registers stay locked.
- R9: Primary control byte bits: [7] run enable, [6] interrupt enable, [5] update permission, [4] debug run, [3] wait run, [2] stop run, [1:0] reserved and read as 0. Secondary byte bits: [7] window-check enable, [4] prescaler enable, [1:0] clock select, others reserved and read as 0.
- R10: A write to address 1 without both strobes set does not count as a key and does not cancel a pending sequence. No write to address 1 changes any configuration output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one word per clock |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_strb | input | 2 | Byte lane enables |
| run_en | output | 1 | Watchdog run enable |
| irq_en | output | 1 | Timeout interrupt enable |
| upd_en | output | 1 | Permission for later reconfiguration |
| dbg_run | output | 1 | Run while halted by a debugger |
| wait_run | output | 1 | Run in wait mode |
| stop_run | output | 1 | Run in stop mode |
| win_chk_en | output | 1 | Window-refresh check enable |
| pre_en | output | 1 | Fixed prescaler enable |
| clk_sel | output | 2 | Counter clock source select |
| tmo_val | output | 16 | Timeout value |
| win_val | output | 16 | Window value |

## Verification
The assertions assume the bus issues at most one write per clock and that its address, data and strobes are valid on every clock where bus_we is high. The assertions on locked stability also assume that nothing other than a bus write, or reset, can change a register. The stimulus drives every bus field on the falling edge and returns bus_we to 0 after each single-cycle write. It pulses reset only between complete transactions, so each write is captured on exactly one rising edge. That lets the key-gap and window distances be placed on exact clock counts.

// File: rtl/wdcfg_pkg.sv
`timescale 1ns/1ps
package wdcfg_pkg;
   // configuration byte slots, in storage order
   localparam int unsigned NUM_CFG_BYTES = 6;
   localparam int unsigned BY_CTRL_A = 0;
   localparam int unsigned BY_CTRL_B = 1;
   localparam int unsigned BY_TMO_L  = 2;
   localparam int unsigned BY_TMO_H  = 3;
   localparam int unsigned BY_WIN_L  = 4;
   localparam int unsigned BY_WIN_H  = 5;

   // primary control byte bit positions
   localparam int unsigned CA_RUN  = 7;
   localparam int unsigned CA_IRQ  = 6;
   localparam int unsigned CA_UPD  = 5;
   localparam int unsigned CA_DBG  = 4;
   localparam int unsigned CA_WAIT = 3;
   localparam int unsigned CA_STOP = 2;

   // secondary control byte bit positions
   localparam int unsigned CB_WIN = 7;
   localparam int unsigned CB_PRE = 4;
   localparam int unsigned CB_CLK = 0;

   localparam logic [7:0] CA_KEEP = 8'hFC;
   localparam logic [7:0] CB_KEEP = 8'h93;
endpackage

// File: rtl/wdcfg_bytereg.sv
`timescale 1ns/1ps
module wdcfg_bytereg #(
   parameter int unsigned   W       = 8,
   parameter logic [W-1:0]  RST_VAL = '0,
   parameter logic [W-1:0]  KEEP    = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W == 0) begin : g_bad_w
      $error("wdcfg_bytereg: W must be nonzero");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (KEEP[b]) begin : g_store
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  bit_q <= RST_VAL[b];
            else if (we) bit_q <= d[b];
         end
         assign q[b] = bit_q;
      end else begin : g_tie
         assign q[b] = 1'b0;
      end
   end
endmodule

// File: rtl/wdcfg_keyseq.sv
`timescale 1ns/1ps
module wdcfg_keyseq #(
   parameter int unsigned        KEY_W    = 16,
   parameter logic [KEY_W-1:0]   KEY_A    = 16'h20C5,
   parameter logic [KEY_W-1:0]   KEY_B    = 16'h28D9,
   parameter int unsigned        KEY_GAP  = 16,
   parameter int unsigned        OPEN_CYC = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_we,
   input  logic [KEY_W-1:0] key_data,
   input  logic             permit,
   output logic             armed,
   output logic             win_open
);
   localparam int unsigned GAP_W  = $clog2(KEY_GAP + 1);
   localparam int unsigned OPEN_W = $clog2(OPEN_CYC + 1);

   if (KEY_GAP < 1) begin : g_bad_gap
      $error("wdcfg_keyseq: KEY_GAP must be at least 1");
   end
   if (OPEN_CYC < 1) begin : g_bad_open
      $error("wdcfg_keyseq: OPEN_CYC must be at least 1");
   end
   if (KEY_A == KEY_B) begin : g_bad_keys
      $error("wdcfg_keyseq: the two keys must differ");
   end

   logic [GAP_W-1:0]  arm_q;
   logic [OPEN_W-1:0] open_q;
   logic              hit_a;
   logic              hit_b;

   assign armed    = (arm_q != '0);
   assign win_open = (open_q != '0);
   assign hit_a    = key_we && permit && (key_data == KEY_A);
   assign hit_b    = key_we && permit && armed && (key_data == KEY_B);

   // first-key tracker: loaded by key A, cleared by any other full key write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          arm_q <= '0;
      else if (hit_a)      arm_q <= GAP_W'(KEY_GAP);
      else if (key_we)     arm_q <= '0;
      else if (armed)      arm_q <= arm_q - GAP_W'(1);
   end

   // update window timer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          open_q <= '0;
      else if (hit_b)      open_q <= OPEN_W'(OPEN_CYC);
      else if (win_open)   open_q <= open_q - OPEN_W'(1);
   end
endmodule

// File: rtl/wdcfg_guard.sv
`timescale 1ns/1ps
module wdcfg_guard #(
   parameter int unsigned       ADDR_W     = 4,
   parameter int unsigned       DATA_W     = 16,
   parameter logic [ADDR_W-1:0] ADDR_CTRL  = ADDR_W'(0),
   parameter logic [ADDR_W-1:0] ADDR_KEY   = ADDR_W'(1),
   parameter logic [ADDR_W-1:0] ADDR_TMO   = ADDR_W'(2),
   parameter logic [ADDR_W-1:0] ADDR_WIN   = ADDR_W'(3),
   parameter logic [15:0]       KEY_A      = 16'h20C5,
   parameter logic [15:0]       KEY_B      = 16'h28D9,
   parameter int unsigned       KEY_GAP    = 16,
   parameter int unsigned       OPEN_CYC   = 128,
   parameter logic [7:0]        RST_CTRL_A = 8'h80,
   parameter logic [7:0]        RST_CTRL_B = 8'h01,
   parameter logic [15:0]       RST_TMO    = 16'h0400,
   parameter logic [15:0]       RST_WIN    = 16'h0000,
   parameter bit                MASK_RSVD  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [15:0]       bus_wdata,
   input  logic [1:0]        bus_strb,
   output logic              run_en,
   output logic              irq_en,
   output logic              upd_en,
   output logic              dbg_run,
   output logic              wait_run,
   output logic              stop_run,
   output logic              win_chk_en,
   output logic              pre_en,
   output logic [1:0]        clk_sel,
   output logic [15:0]       tmo_val,
   output logic [15:0]       win_val
);
   import wdcfg_pkg::*;

   localparam int unsigned STRB_W = DATA_W / 8;

   if (DATA_W != 16) begin : g_bad_data_w
      $error("wdcfg_guard: DATA_W must be 16");
   end
   if (ADDR_CTRL == ADDR_KEY || ADDR_TMO == ADDR_KEY || ADDR_WIN == ADDR_KEY ||
       ADDR_CTRL == ADDR_TMO || ADDR_CTRL == ADDR_WIN || ADDR_TMO == ADDR_WIN) begin : g_bad_map
      $error("wdcfg_guard: register addresses must be distinct");
   end

   function automatic logic [ADDR_W-1:0] word_addr(input int unsigned slot);
      case (slot / 2)
         0:       return ADDR_CTRL;
         1:       return ADDR_TMO;
         default: return ADDR_WIN;
      endcase
   endfunction

   function automatic logic [7:0] rst_byte(input int unsigned slot);
      case (slot)
         BY_CTRL_A: return RST_CTRL_A;
         BY_CTRL_B: return RST_CTRL_B;
         BY_TMO_L:  return RST_TMO[7:0];
         BY_TMO_H:  return RST_TMO[15:8];
         BY_WIN_L:  return RST_WIN[7:0];
         default:   return RST_WIN[15:8];
      endcase
   endfunction

   function automatic logic [7:0] keep_byte(input int unsigned slot);
      if (!MASK_RSVD)           return 8'hFF;
      else if (slot == BY_CTRL_A) return CA_KEEP;
      else if (slot == BY_CTRL_B) return CB_KEEP;
      else                      return 8'hFF;
   endfunction

   logic [NUM_CFG_BYTES-1:0] byte_we;
   logic [7:0]               cfg_byte [NUM_CFG_BYTES];
   logic                     cfg_done;
   logic                     win_open;
   logic                     key_armed;
   logic                     wr_ok;
   logic                     key_we;
   logic                     permit;

   assign wr_ok  = !cfg_done || win_open;
   assign key_we = bus_we && (bus_addr == ADDR_KEY) && (bus_strb == {STRB_W{1'b1}});
   assign permit = !cfg_done || cfg_byte[BY_CTRL_A][CA_UPD];

   wdcfg_keyseq #(
      .KEY_W    (16),
      .KEY_A    (KEY_A),
      .KEY_B    (KEY_B),
      .KEY_GAP  (KEY_GAP),
      .OPEN_CYC (OPEN_CYC)
   ) u_keyseq (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_we   (key_we),
      .key_data (bus_wdata),
      .permit   (permit),
      .armed    (key_armed),
      .win_open (win_open)
   );

   for (genvar g = 0; g < NUM_CFG_BYTES; g++) begin : g_byte
      localparam int unsigned LANE = g % 2;
      assign byte_we[g] = wr_ok && bus_we && (bus_addr == word_addr(g)) && bus_strb[LANE];
      wdcfg_bytereg #(
         .W       (8),
         .RST_VAL (rst_byte(g) & keep_byte(g)),
         .KEEP    (keep_byte(g))
      ) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (byte_we[g]),
         .d     (bus_wdata[LANE*8 +: 8]),
         .q     (cfg_byte[g])
      );
   end

   // commit flag: set by the first accepted primary control write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cfg_done <= 1'b0;
      else if (byte_we[BY_CTRL_A]) cfg_done <= 1'b1;
   end

   assign run_en     = cfg_byte[BY_CTRL_A][CA_RUN];
   assign irq_en     = cfg_byte[BY_CTRL_A][CA_IRQ];
   assign upd_en     = cfg_byte[BY_CTRL_A][CA_UPD];
   assign dbg_run    = cfg_byte[BY_CTRL_A][CA_DBG];
   assign wait_run   = cfg_byte[BY_CTRL_A][CA_WAIT];
   assign stop_run   = cfg_byte[BY_CTRL_A][CA_STOP];
   assign win_chk_en = cfg_byte[BY_CTRL_B][CB_WIN];
   assign pre_en     = cfg_byte[BY_CTRL_B][CB_PRE];
   assign clk_sel    = cfg_byte[BY_CTRL_B][CB_CLK +: 2];
   assign tmo_val    = {cfg_byte[BY_TMO_H], cfg_byte[BY_TMO_L]};
   assign win_val    = {cfg_byte[BY_WIN_H], cfg_byte[BY_WIN_L]};
endmodule

// File: rtl/wdcfg_guard_chk.sv
`timescale 1ns/1ps
module wdcfg_guard_chk #(
   parameter int unsigned       ADDR_W   = 4,
   parameter logic [ADDR_W-1:0] ADDR_KEY = ADDR_W'(1),
   parameter logic [15:0]       KEY_B    = 16'h28D9,
   parameter logic [15:0]       RST_TMO  = 16'h0400,
   parameter logic [15:0]       RST_WIN  = 16'h0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [15:0]       bus_wdata,
   input logic [1:0]        bus_strb,
   input logic              cfg_done,
   input logic              win_open,
   input logic              upd_en,
   input logic [15:0]       tmo_val,
   input logic [15:0]       win_val
);
   // R1
   reset_default_chk: assert property (@(posedge clk)
      !rst_n |=> (tmo_val == RST_TMO && win_val == RST_WIN && !cfg_done));

   // R3
   commit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> cfg_done);

   // R3
   locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_done && !win_open) |=> ($stable(tmo_val) && $stable(win_val)));

   // R4
   open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_open) |-> $past(bus_we && bus_addr == ADDR_KEY &&
                                bus_wdata == KEY_B && bus_strb == 2'b11));

   // R8
   frozen_no_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_done && !upd_en && !win_open) |=> !win_open);
endmodule

bind wdcfg_guard wdcfg_guard_chk #(
   .ADDR_W   (ADDR_W),
   .ADDR_KEY (ADDR_KEY),
   .KEY_B    (KEY_B),
   .RST_TMO  (RST_TMO),
   .RST_WIN  (RST_WIN)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_strb  (bus_strb),
   .cfg_done  (cfg_done),
   .win_open  (win_open),
   .upd_en    (upd_en),
   .tmo_val   (tmo_val),
   .win_val   (win_val)
);

// File: tb/wdcfg_guard_tb_top.sv
`timescale 1ns/1ps
module wdcfg_guard_tb_top;
   localparam logic [3:0] A_CTRL = 4'd0;
   localparam logic [3:0] A_KEY  = 4'd1;
   localparam logic [3:0] A_TMO  = 4'd2;
   localparam logic [3:0] A_WIN  = 4'd3;
   localparam logic [15:0] K1 = 16'h20C5;
   localparam logic [15:0] K2 = 16'h28D9;

   typedef struct packed {
      logic [3:0]  a;
      logic [15:0] d;
      logic [1:0]  s;
      logic [15:0] et;
      logic [15:0] ew;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VEC [NV] = '{
      '{a: 4'd2, d: 16'h1234, s: 2'b11, et: 16'h1234, ew: 16'h0000},
      '{a: 4'd2, d: 16'hABCD, s: 2'b01, et: 16'h12CD, ew: 16'h0000},
      '{a: 4'd2, d: 16'hEF00, s: 2'b10, et: 16'hEFCD, ew: 16'h0000},
      '{a: 4'd3, d: 16'h5566, s: 2'b11, et: 16'hEFCD, ew: 16'h5566},
      '{a: 4'd3, d: 16'h9988, s: 2'b10, et: 16'hEFCD, ew: 16'h9966},
      '{a: 4'd2, d: 16'hFFFF, s: 2'b00, et: 16'hEFCD, ew: 16'h9966},
      '{a: 4'd1, d: 16'h1234, s: 2'b11, et: 16'hEFCD, ew: 16'h9966}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [1:0]  bus_strb = '0;
   logic        run_en, irq_en, upd_en, dbg_run, wait_run, stop_run;
   logic        win_chk_en, pre_en;
   logic [1:0]  clk_sel;
   logic [15:0] tmo_val, win_val;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   wdcfg_guard dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_strb(bus_strb),
      .run_en(run_en), .irq_en(irq_en), .upd_en(upd_en), .dbg_run(dbg_run),
      .wait_run(wait_run), .stop_run(stop_run), .win_chk_en(win_chk_en),
      .pre_en(pre_en), .clk_sel(clk_sel), .tmo_val(tmo_val), .win_val(win_val)
   );

   function automatic logic [5:0] ctrl_a_bits();
      return {run_en, irq_en, upd_en, dbg_run, wait_run, stop_run};
   endfunction

   function automatic logic [3:0] ctrl_b_bits();
      return {win_chk_en, pre_en, clk_sel};
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // starts and ends on a falling edge; captured on the rising edge between
   task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] s);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_strb = s;
      @(negedge clk);
      bus_we = 1'b0; bus_strb = 2'b00;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset defaults
      check("R1 ctrl_a", {10'd0, ctrl_a_bits()}, 16'h0020);
      check("R1 ctrl_b", {12'd0, ctrl_b_bits()}, 16'h0001);
      check("R1 tmo", tmo_val, 16'h0400);
      check("R1 win", win_val, 16'h0000);

      // R2 byte-lane writes before commit; R10 key address leaves config alone
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i].a, VEC[i].d, VEC[i].s);
         check("R2/R10 vec tmo", tmo_val, VEC[i].et);
         check("R2/R10 vec win", win_val, VEC[i].ew);
      end

      // R9 secondary byte fields, no commit from high lane only
      wr(A_CTRL, 16'h9300, 2'b10);
      check("R9 ctrl_b", {12'd0, ctrl_b_bits()}, 16'h000F);
      wr(A_TMO, 16'h0777, 2'b11);
      check("R3 no commit from high lane", tmo_val, 16'h0777);
      // R9 primary fields, commit (R3)
      wr(A_CTRL, 16'h00FC, 2'b01);
      check("R9 ctrl_a", {10'd0, ctrl_a_bits()}, 16'h003F);
      check("R9 ctrl_b kept", {12'd0, ctrl_b_bits()}, 16'h000F);

      // R3 locked after commit
      wr(A_TMO, 16'h1111, 2'b11);
      check("R3 tmo locked", tmo_val, 16'h0777);
      wr(A_CTRL, 16'h0000, 2'b11);
      check("R3 ctrl locked", {10'd0, ctrl_a_bits()}, 16'h003F);

      // R4 second key at the last allowed clock (16 after first)
      wr(A_KEY, K1, 2'b11);
      idle(15);
      wr(A_KEY, K2, 2'b11);
      wr(A_TMO, 16'h2222, 2'b11);
      check("R4 unlock at gap 16", tmo_val, 16'h2222);
      idle(130);

      // R7 window edges: k=128 accepted, k=129 ignored
      wr(A_KEY, K1, 2'b11);
      wr(A_KEY, K2, 2'b11);
      idle(127);
      wr(A_TMO, 16'h3333, 2'b11);
      check("R7 write at 128", tmo_val, 16'h3333);
      wr(A_TMO, 16'h4444, 2'b11);
      check("R7 write at 129", tmo_val, 16'h3333);

      // R5 late second key
      wr(A_KEY, K1, 2'b11);
      idle(16);
      wr(A_KEY, K2, 2'b11);
      wr(A_TMO, 16'h5555, 2'b11);
      check("R5 late key", tmo_val, 16'h3333);

      // R6 foreign value between keys
      wr(A_KEY, K1, 2'b11);
      wr(A_KEY, 16'h02A6, 2'b11);
      wr(A_KEY, K2, 2'b11);
      wr(A_TMO, 16'h6666, 2'b11);
      check("R6 broken sequence", tmo_val, 16'h3333);

      // R10 partial-strobe key write neither counts nor cancels
      wr(A_KEY, K1, 2'b11);
      wr(A_KEY, K2, 2'b01);
      check("R10 partial key no effect", tmo_val, 16'h3333);
      wr(A_KEY, K2, 2'b11);
      wr(A_TMO, 16'h7777, 2'b11);
      check("R10 sequence survived", tmo_val, 16'h7777);
      wr(A_CTRL, 16'h00D8, 2'b01);
      check("R9 rewrite upd clear", {10'd0, ctrl_a_bits()}, 16'h0036);
      idle(130);

      // R8 no unlock once committed with update bit clear
      wr(A_KEY, K1, 2'b11);
      wr(A_KEY, K2, 2'b11);
      wr(A_TMO, 16'h8888, 2'b11);
      check("R8 frozen tmo", tmo_val, 16'h7777);
      wr(A_CTRL, 16'h00FC, 2'b01);
      check("R8 frozen ctrl", {10'd0, ctrl_a_bits()}, 16'h0036);

      // R1 reset restores defaults and first-write permission
      rst_n = 1'b0;
      idle(1);
      rst_n = 1'b1;
      idle(1);
      check("R1 tmo after reset", tmo_val, 16'h0400);
      check("R1 ctrl after reset", {10'd0, ctrl_a_bits()}, 16'h0020);
      check("R1 ctrl_b after reset", {12'd0, ctrl_b_bits()}, 16'h0001);
      wr(A_TMO, 16'h9999, 2'b11);
      check("R1 first write restored", tmo_val, 16'h9999);

      finish_run();
   end
endmodule